// File: doc/BRIEF.md
# Tagged DMA Command Queue

This block sits between a local processor and a transfer engine. The processor pushes transfer commands into a sixteen-slot queue. Each command carries an address, a byte count, a 5-bit tag group and an ordering kind. The queue offers commands to the engine one at a time over a valid/ready handshake. A command is offered only once its ordering rules allow it to start. The engine later reports each finished transfer by the slot number it was given at issue, and the slot is then freed.

Ordering is kept per tag group. A fenced command waits for the earlier commands of its own group. A barriered command waits the same way and also holds back the later commands of its group until it has started. A standalone synchronising command holds back everything behind it until every command ahead of it has finished. It never reaches the engine. Among the commands that may start, the oldest goes first, and a blocked command never stalls an unrelated group.

Software reads tag-group completion through a query port driven by a small state machine with four states. QS_IDLE accepts a request. An immediate request goes QS_IDLE → QS_REPLY. An any-group wait goes QS_IDLE → QS_ANY, and QS_ANY → QS_REPLY once a masked group is idle. An all-group wait goes QS_IDLE → QS_ALL, and QS_ALL → QS_REPLY once every masked group is idle. QS_REPLY → QS_IDLE always follows after one cycle.

Top module: `dma_tag_queue`

## Requirements
- R1: The queue holds at most 16 commands. `cmd_ready` is low exactly when all 16 slots are occupied, and a command presented then is not taken. `vacancy` always equals the number of free slots, from 16 after reset down to 0.
- R2: For `cmd_kind` 0, 1 and 2 the byte count must be 1, 2, 4, 8, or a non-zero multiple of 16 no larger than 16384. Any other count raises `cmd_err` in the same cycle, and the command is not stored. A command of kind 3 ignores its byte count.
- R3: Among the commands allowed to start, the oldest is offered first. A command blocked by ordering does not stop a younger command of another tag group from being offered.
- R4: A fenced command (`cmd_kind` 1) is not offered while any older command of its tag group is still queued or in flight. Younger plain commands of that group may be offered before it.
- R5: A barriered command (`cmd_kind` 2) is not offered while any older command of its group is queued or in flight. No younger command of that group is offered until the barriered command has been issued.
- R6: A standalone synchronising command (`cmd_kind` 3) blocks every younger command of every group. It leaves the queue without being offered, one cycle after no older command remains, and it frees its slot at that point.
- R7: A tag group is idle when no queued or in-flight command (kinds 0–2) carries its tag. Bit n of `q_status` stands for group n.
- R8: A query with `q_mode` 0 (immediate) raises `q_done` for one cycle, in the cycle after the request. `q_status` then equals the idle groups ANDed with `q_mask`, as they were in the request cycle.
- R9: A query with `q_mode` 1 (any) raises `q_done` only after at least one masked group is idle, with that group's bit set in `q_status`. A zero mask answers at once.
- R10: A query with `q_mode` 2 (all) raises `q_done` only once every masked group is idle, and `q_status` then equals `q_mask`.
- R11: `vac_event` is high for one cycle after each cycle in which a slot was freed, by a completion or by the retirement of a synchronising command.
- R12: An offered command moves to in flight on the edge where `iss_valid` and `iss_ready` are both high. Its slot is freed on the edge where `done_valid` is high with `done_id` equal to the `iss_id` it was issued with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command presented |
| cmd_ready | output | 1 | A slot is free |
| cmd_kind | input | 2 | 0 plain, 1 fenced, 2 barriered, 3 standalone sync |
| cmd_tag | input | 5 | Tag group of the command |
| cmd_addr | input | 32 | Transfer address |
| cmd_size | input | 15 | Transfer byte count |
| cmd_err | output | 1 | Presented command has an illegal byte count |
| iss_valid | output | 1 | A command is offered to the engine |
| iss_ready | input | 1 | Engine takes the offered command |
| iss_id | output | 4 | Slot number of the offered command |
| iss_tag | output | 5 | Tag of the offered command |
| iss_addr | output | 32 | Address of the offered command |
| iss_size | output | 15 | Byte count of the offered command |
| done_valid | input | 1 | Engine reports a finished transfer |
| done_id | input | 4 | Slot number of the finished transfer |
| vacancy | output | 5 | Number of free slots |
| vac_event | output | 1 | A slot was freed in the previous cycle |
| q_req | input | 1 | Tag-status query request |
| q_mode | input | 2 | 0 immediate, 1 any, 2 all |
| q_mask | input | 32 | Tag groups of interest |
| q_busy | output | 1 | Query in progress |
| q_done | output | 1 | Query answer valid |
| q_status | output | 32 | Idle masked groups at the answer |

## Verification
The ordering logic is driven with mixed groups in which an older command is in flight. Each pattern shows whether a blocked command wrongly stalls another group, whether a fence is wrongly held behind a younger plain command, and whether a barrier releases its followers too early. A synchronising command is placed between two groups to show that it holds everything back, and to show the extra cycle it takes to retire. The queue is filled to capacity, then drained, to expose age order and the vacancy count at both ends. Byte counts just inside and just outside the legal set separate the size check from plain enqueue. The three query modes are run against a group that is still in flight and against a pair of groups finishing at different times. This shows that an all-wait does not answer after only one of them.

// File: rtl/dq_pkg.sv
package dq_pkg;
    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_FENCE = 2'd1,
        K_BAR   = 2'd2,
        K_SYNC  = 2'd3
    } kind_e;

    localparam logic [1:0] QM_NOW = 2'd0;
    localparam logic [1:0] QM_ANY = 2'd1;
    localparam logic [1:0] QM_ALL = 2'd2;

    typedef enum logic [1:0] {
        QS_IDLE,
        QS_ANY,
        QS_ALL,
        QS_REPLY
    } qstate_e;
endpackage

// File: rtl/dq_size_check.sv
module dq_size_check #(
    parameter int SIZE_W    = 15,
    parameter int MAX_BYTES = 16384
) (
    input  logic [SIZE_W-1:0] size,
    output logic              legal
);
    localparam logic [SIZE_W-1:0] MAXV = SIZE_W'(MAX_BYTES);

    logic small_pow2;
    logic line_mult;

    always_comb begin
        small_pow2 = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) ||
                     (size == SIZE_W'(4)) || (size == SIZE_W'(8));
        line_mult  = (size[3:0] == 4'd0) && (size != '0) && (size <= MAXV);
        legal      = small_pow2 || line_mult;
    end
endmodule

// File: rtl/dq_pick.sv
module dq_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  older [N],
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    for (genvar i = 0; i < N; i++) begin : g_gnt
        assign gnt[i] = req[i] & ~(|(req & older[i]));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IW'(i);
        end
    end

    assign any = |req;

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (any == (|gnt))); // R3
endmodule

// File: rtl/dq_tag_wait.sv
module dq_tag_wait
    import dq_pkg::*;
#(
    parameter int NT = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_req,
    input  logic [1:0]    q_mode,
    input  logic [NT-1:0] q_mask,
    input  logic [NT-1:0] idle,
    output logic          q_busy,
    output logic          q_done,
    output logic [NT-1:0] q_status
);
    qstate_e       st, nxt;
    logic [NT-1:0] mask_q;
    logic [NT-1:0] stat_q;
    logic          hit_any, hit_all;

    assign hit_any = (|(idle & mask_q)) || (mask_q == '0);
    assign hit_all = ((idle & mask_q) == mask_q);

    always_comb begin
        nxt = st;
        unique case (st)
            QS_IDLE: begin
                if (q_req) begin
                    if (q_mode == QM_ANY)      nxt = QS_ANY;
                    else if (q_mode == QM_ALL) nxt = QS_ALL;
                    else                       nxt = QS_REPLY;
                end
            end
            QS_ANY:   if (hit_any) nxt = QS_REPLY;
            QS_ALL:   if (hit_all) nxt = QS_REPLY;
            QS_REPLY: nxt = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= QS_IDLE;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            st <= nxt;
            if (st == QS_IDLE && q_req) begin
                mask_q <= q_mask;
                stat_q <= idle & q_mask;
            end else if (st == QS_ANY || st == QS_ALL) begin
                stat_q <= idle & mask_q;
            end
        end
    end

    always_comb begin
        q_busy   = 1'b1;
        q_done   = 1'b0;
        q_status = '0;
        unique case (st)
            QS_IDLE:  q_busy = 1'b0;
            QS_ANY:   q_busy = 1'b1;
            QS_ALL:   q_busy = 1'b1;
            QS_REPLY: begin
                q_done   = 1'b1;
                q_status = stat_q;
            end
        endcase
    end

    AST_ANY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (q_done && $past(st) == QS_ANY && mask_q != '0) |-> (|(q_status & mask_q))); // R9
    AST_ALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (q_done && $past(st) == QS_ALL) |-> (q_status == mask_q)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q_done |=> !q_done); // R8
endmodule

// File: rtl/dma_tag_queue.sv
module dma_tag_queue
    import dq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TAG_W     = 5,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 15,
    parameter int MAX_BYTES = 16384,
    localparam int IDW      = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int NTAG     = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_kind,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic              cmd_err,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [IDW-1:0]    iss_id,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [SIZE_W-1:0] iss_size,
    input  logic              done_valid,
    input  logic [IDW-1:0]    done_id,
    output logic [CW-1:0]     vacancy,
    output logic              vac_event,
    input  logic              q_req,
    input  logic [1:0]        q_mode,
    input  logic [NTAG-1:0]   q_mask,
    output logic              q_busy,
    output logic              q_done,
    output logic [NTAG-1:0]   q_status
);
    logic [DEPTH-1:0]  vld, isd;
    logic [DEPTH-1:0]  older [DEPTH];
    logic [TAG_W-1:0]  e_tag  [DEPTH];
    kind_e             e_kind [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [SIZE_W-1:0] e_size [DEPTH];

    logic [DEPTH-1:0]  is_sync, bar_wait, req, retire, free_mask, gnt;
    logic [IDW-1:0]    slot, gidx;
    logic              full, size_ok, cmd_ok, enq, gany;
    logic [NTAG-1:0]   busy_tags;

    dq_size_check #(.SIZE_W(SIZE_W), .MAX_BYTES(MAX_BYTES)) u_size (
        .size (cmd_size),
        .legal(size_ok)
    );

    assign full      = &vld;
    assign cmd_ready = ~full;
    assign cmd_ok    = (cmd_kind == K_SYNC) || size_ok;
    assign enq       = cmd_valid & ~full & cmd_ok;
    assign cmd_err   = cmd_valid & ~full & ~cmd_ok;

    always_comb begin
        slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) slot = IDW'(i);
        end
    end

    for (genvar j = 0; j < DEPTH; j++) begin : g_kind
        assign is_sync[j]  = (e_kind[j] == K_SYNC);
        assign bar_wait[j] = (e_kind[j] == K_BAR) && !isd[j];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_elig
        logic [DEPTH-1:0] same, older_v;
        logic             blk_sync, blk_same, blk_bar;
        for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
            assign same[j] = vld[j] && !is_sync[j] && (e_tag[j] == e_tag[i]);
        end
        assign older_v  = vld & older[i];
        assign blk_sync = |(older_v & is_sync);
        assign blk_same = |(older_v & same);
        assign blk_bar  = |(older_v & same & bar_wait);
        assign req[i]   = vld[i] & ~isd[i] & ~is_sync[i] & ~blk_sync & ~blk_bar &
                          ((e_kind[i] == K_PLAIN) | ~blk_same);
        assign retire[i] = vld[i] & is_sync[i] & ~(|older_v);
    end

    dq_pick #(.N(DEPTH), .IW(IDW)) u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .older(older),
        .gnt  (gnt),
        .idx  (gidx),
        .any  (gany)
    );

    assign iss_valid = gany;
    assign iss_id    = gidx;
    assign iss_tag   = e_tag[gidx];
    assign iss_addr  = e_addr[gidx];
    assign iss_size  = e_size[gidx];

    assign free_mask = retire | (done_valid ? (DEPTH'(1) << done_id) : '0);
    assign vacancy   = CW'(DEPTH) - CW'($countones(vld));

    always_comb begin
        busy_tags = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && !is_sync[i]) busy_tags[e_tag[i]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (enq) begin
            e_tag[slot]  <= cmd_tag;
            e_kind[slot] <= kind_e'(cmd_kind);
            e_addr[slot] <= cmd_addr;
            e_size[slot] <= cmd_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld       <= '0;
            isd       <= '0;
            vac_event <= 1'b0;
            for (int i = 0; i < DEPTH; i++) older[i] <= '0;
        end else begin
            vac_event <= |free_mask;
            for (int i = 0; i < DEPTH; i++) begin
                if (free_mask[i]) begin
                    vld[i] <= 1'b0;
                    isd[i] <= 1'b0;
                end
            end
            if (iss_valid && iss_ready) isd[gidx] <= 1'b1;
            if (enq) begin
                vld[slot] <= 1'b1;
                isd[slot] <= 1'b0;
                for (int j = 0; j < DEPTH; j++) older[j][slot] <= 1'b0;
                older[slot] <= vld & ~free_mask;
            end
        end
    end

    dq_tag_wait #(.NT(NTAG)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_req   (q_req),
        .q_mode  (q_mode),
        .q_mask  (q_mask),
        .idle    (~busy_tags),
        .q_busy  (q_busy),
        .q_done  (q_done),
        .q_status(q_status)
    );

    AST_NO_SYNC_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (e_kind[iss_id] != K_SYNC)); // R6
    AST_ISSUE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (vld[iss_id] && !isd[iss_id])); // R12
    AST_DONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (vld[done_id] && isd[done_id])); // R12
    AST_ERR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !enq) |=> (vacancy >= $past(vacancy))); // R2
    AST_VACANCY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (vacancy <= CW'(DEPTH)) && (cmd_ready == (vacancy != '0))); // R1
endmodule

// File: tb/dma_tag_queue_test.sv
module dma_tag_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_kind = '0;
    logic [4:0]  cmd_tag = '0;
    logic [31:0] cmd_addr = '0;
    logic [14:0] cmd_size = '0;
    logic        cmd_err;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [3:0]  iss_id;
    logic [4:0]  iss_tag;
    logic [31:0] iss_addr;
    logic [14:0] iss_size;
    logic        done_valid = 1'b0;
    logic [3:0]  done_id = '0;
    logic [4:0]  vacancy;
    logic        vac_event;
    logic        q_req = 1'b0;
    logic [1:0]  q_mode = '0;
    logic [31:0] q_mask = '0;
    logic        q_busy, q_done;
    logic [31:0] q_status;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    dma_tag_queue uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_tag(cmd_tag), .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_err(cmd_err),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_id(iss_id),
        .iss_tag(iss_tag), .iss_addr(iss_addr), .iss_size(iss_size),
        .done_valid(done_valid), .done_id(done_id),
        .vacancy(vacancy), .vac_event(vac_event),
        .q_req(q_req), .q_mode(q_mode), .q_mask(q_mask),
        .q_busy(q_busy), .q_done(q_done), .q_status(q_status)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enq(input logic [1:0] k, input logic [4:0] t, input logic [31:0] a,
                       input logic [14:0] s, output logic err);
        cmd_valid = 1'b1; cmd_kind = k; cmd_tag = t; cmd_addr = a; cmd_size = s;
        #1 err = cmd_err;
        tick;
        cmd_valid = 1'b0;
    endtask

    task automatic take(input string rq, input logic [31:0] exp_addr, output logic [3:0] id);
        chk(rq, {63'd0, iss_valid}, 64'd1);
        chk(rq, {32'd0, iss_addr}, {32'd0, exp_addr});
        id = iss_id;
        iss_ready = 1'b1;
        tick;
        iss_ready = 1'b0;
    endtask

    task automatic finish(input logic [3:0] id);
        done_valid = 1'b1; done_id = id;
        tick;
        done_valid = 1'b0;
    endtask

    task automatic query(input logic [1:0] m, input logic [31:0] msk);
        q_req = 1'b1; q_mode = m; q_mask = msk;
        tick;
        q_req = 1'b0;
    endtask

    task automatic wait_done;
        for (int k = 0; k < 10; k++) begin
            if (q_done) break;
            tick;
        end
    endtask

    task automatic t_reset;
        chk("R1 reset ready", {63'd0, cmd_ready}, 64'd1);
        chk("R1 reset vacancy", {59'd0, vacancy}, 64'd16);
        chk("R12 reset no offer", {63'd0, iss_valid}, 64'd0);
        chk("R8 reset query idle", {62'd0, q_busy, q_done}, 64'd0);
    endtask

    task automatic t_size;
        logic e;
        logic [3:0] id;
        enq(2'd0, 5'd1, 32'h10, 15'd3, e);     chk("R2 size 3", {63'd0, e}, 64'd1);
        chk("R2 size 3 not stored", {59'd0, vacancy}, 64'd16);
        enq(2'd0, 5'd1, 32'h20, 15'd0, e);     chk("R2 size 0", {63'd0, e}, 64'd1);
        enq(2'd0, 5'd1, 32'h30, 15'd16400, e); chk("R2 size 16400", {63'd0, e}, 64'd1);
        enq(2'd0, 5'd1, 32'h40, 15'd24, e);    chk("R2 size 24", {63'd0, e}, 64'd1);
        enq(2'd0, 5'd1, 32'h50, 15'd8, e);     chk("R2 size 8", {63'd0, e}, 64'd0);
        enq(2'd0, 5'd1, 32'h60, 15'd16384, e); chk("R2 size 16384", {63'd0, e}, 64'd0);
        enq(2'd0, 5'd1, 32'h70, 15'd32, e);    chk("R2 size 32", {63'd0, e}, 64'd0);
        enq(2'd3, 5'd0, 32'h0, 15'd3, e);      chk("R2 sync ignores size", {63'd0, e}, 64'd0);
        chk("R2 stored count", {59'd0, vacancy}, 64'd12);
        take("R3 oldest 8", 32'h50, id);     finish(id);
        take("R3 oldest 16384", 32'h60, id); finish(id);
        take("R3 oldest 32", 32'h70, id);    finish(id);
        tick;
        chk("R6 sync gone", {59'd0, vacancy}, 64'd16);
    endtask

    task automatic t_fence;
        logic e;
        logic [3:0] a, b, c;
        enq(2'd0, 5'd3, 32'h100, 15'd16, e);
        enq(2'd1, 5'd3, 32'h200, 15'd16, e);
        enq(2'd0, 5'd4, 32'h300, 15'd16, e);
        take("R3 oldest first", 32'h100, a);
        take("R3 other group passes", 32'h300, b);
        chk("R4 fence held", {63'd0, iss_valid}, 64'd0);
        finish(a);
        take("R4 fence released", 32'h200, c);
        finish(b); finish(c);
        enq(2'd0, 5'd5, 32'h400, 15'd16, e);
        take("R4 setup", 32'h400, a);
        enq(2'd1, 5'd5, 32'h500, 15'd16, e);
        enq(2'd0, 5'd5, 32'h600, 15'd16, e);
        take("R4 younger plain passes fence", 32'h600, b);
        finish(a);
        take("R4 fence after group done", 32'h500, c);
        finish(b); finish(c);
    endtask

    task automatic t_barrier;
        logic e;
        logic [3:0] a, b, c, d;
        enq(2'd0, 5'd6, 32'h700, 15'd16, e);
        take("R5 setup", 32'h700, a);
        enq(2'd2, 5'd6, 32'h800, 15'd16, e);
        enq(2'd0, 5'd6, 32'h900, 15'd16, e);
        enq(2'd0, 5'd7, 32'hA00, 15'd16, e);
        take("R5 other group passes", 32'hA00, b);
        chk("R5 barrier holds group", {63'd0, iss_valid}, 64'd0);
        finish(a);
        take("R5 barrier released", 32'h800, c);
        take("R5 follower after barrier", 32'h900, d);
        finish(b); finish(c); finish(d);
    endtask

    task automatic t_sync;
        logic e;
        logic [3:0] a, b;
        enq(2'd0, 5'd8, 32'hB00, 15'd16, e);
        take("R6 setup", 32'hB00, a);
        enq(2'd3, 5'd0, 32'h0, 15'd0, e);
        enq(2'd0, 5'd9, 32'hC00, 15'd16, e);
        chk("R6 sync blocks other group", {63'd0, iss_valid}, 64'd0);
        chk("R1 vacancy three used", {59'd0, vacancy}, 64'd13);
        finish(a);
        chk("R6 still blocked on retire cycle", {63'd0, iss_valid}, 64'd0);
        chk("R6 sync still held", {59'd0, vacancy}, 64'd14);
        tick;
        chk("R6 sync freed slot", {59'd0, vacancy}, 64'd15);
        chk("R11 event on sync retire", {63'd0, vac_event}, 64'd1);
        take("R6 younger released", 32'hC00, b);
        finish(b);
    endtask

    task automatic t_full;
        logic e;
        logic [3:0] id;
        for (int i = 0; i < 16; i++) enq(2'd0, 5'd10, 32'h1000 + 32'(i * 16), 15'd16, e);
        chk("R1 full vacancy", {59'd0, vacancy}, 64'd0);
        chk("R1 full not ready", {63'd0, cmd_ready}, 64'd0);
        cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_tag = 5'd11; cmd_addr = 32'hDEAD; cmd_size = 15'd16;
        tick;
        cmd_valid = 1'b0;
        chk("R1 refused while full", {59'd0, vacancy}, 64'd0);
        take("R3 drain first", 32'h1000, id);
        chk("R11 no event before free", {63'd0, vac_event}, 64'd0);
        finish(id);
        chk("R11 event after free", {63'd0, vac_event}, 64'd1);
        chk("R1 one free", {59'd0, vacancy}, 64'd1);
        tick;
        chk("R11 event single cycle", {63'd0, vac_event}, 64'd0);
        for (int i = 1; i < 16; i++) begin
            take("R3 drain age order", 32'h1000 + 32'(i * 16), id);
            finish(id);
        end
        chk("R1 empty again", {59'd0, vacancy}, 64'd16);
    endtask

    task automatic t_query;
        logic e;
        logic [3:0] a, b, c;
        enq(2'd0, 5'd11, 32'hD00, 15'd16, e);
        take("R7 setup", 32'hD00, a);
        query(2'd0, 32'h0000_1800);
        chk("R8 immediate done", {63'd0, q_done}, 64'd1);
        chk("R7 in-flight group busy", {32'd0, q_status}, 64'h1000);
        tick;
        query(2'd1, 32'h0000_0800);
        for (int k = 0; k < 3; k++) begin
            chk("R9 any waits", {63'd0, q_done}, 64'd0);
            tick;
        end
        finish(a);
        wait_done;
        chk("R9 any answered", {63'd0, q_done}, 64'd1);
        chk("R9 any status", {32'd0, q_status}, 64'h800);
        tick;
        enq(2'd0, 5'd13, 32'hE00, 15'd16, e);
        enq(2'd0, 5'd14, 32'hF00, 15'd16, e);
        take("R10 setup a", 32'hE00, b);
        take("R10 setup b", 32'hF00, c);
        query(2'd2, 32'h0000_6000);
        finish(b);
        for (int k = 0; k < 3; k++) begin
            chk("R10 all waits for both", {63'd0, q_done}, 64'd0);
            tick;
        end
        finish(c);
        wait_done;
        chk("R10 all answered", {63'd0, q_done}, 64'd1);
        chk("R10 all status", {32'd0, q_status}, 64'h6000);
        tick;
        chk("R8 back to idle", {63'd0, q_busy}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_size;
        t_fence;
        t_barrier;
        t_sync;
        t_full;
        t_query;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule